// File: doc/BRIEF.md
# Bit-Stream Frame Deframer with Escape Marking

This block sits behind a bit-recovery stage and turns a stream of already line-decoded bits into bytes. Each incoming bit arrives with a one-cycle strobe. The block watches for the frame delimiter pattern and for the abort pattern. It removes the zero that a transmitter inserts after five consecutive ones. It packs the remaining bits into bytes, least significant bit first.

Its output is one byte-wide stream that a downstream parser reads without any side band. Every delimiter the block sees is forwarded as the raw delimiter byte 0x7E. A received data byte whose value equals 0x7E, 0x7F or 0x1B is sent after a prefix byte 0x1B, so that framing and data can always be told apart.

The receiver has only two states, armed and disarmed. A delimiter arms it. An abort pattern disarms it. So does a byte that has to be sent while the consumer signals that it cannot take one.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, out_vld is low, reception is disarmed and the bit history is all zeros. Until a delimiter has been seen, no byte is produced.
- R2: Bits shift into an 8-bit history, newest at bit 0. When the history equals 0x7E (the bits 0,1,1,1,1,1,1,0 in arrival order) and out_rdy is high, reception is armed and the byte assembly restarts. The byte 0x7E appears on out_byte with out_vld high in the cycle after the strobe.
- R3: While disarmed, all bits other than those completing a delimiter have no effect on the output.
- R4: While armed, a history whose low seven bits are all ones disarms reception. The partly assembled byte is discarded.
- R5: While armed, a zero bit that follows five consecutive ones is a stuffed bit and is dropped from assembly.
- R6: Kept bits fill a byte from bit 0 upward. The eighth kept bit completes the byte, which is output. The next kept bit starts a new byte.
- R7: A completed byte equal to 0x7E, 0x7F or 0x1B is output as two beats: 0x1B in the cycle after the strobe, then the byte in the following cycle.
- R8: A delimiter seen while out_rdy is low produces no output and leaves reception disarmed.
- R9: A byte completed while out_rdy is low is dropped along with any escape prefix, and reception is disarmed.
- R10: Bit strobes are at least two cycles apart. out_vld is high only in the cycle after a strobe, or in the second beat of an escaped pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Strobe: bit_in holds a new bit |
| bit_in | input | 1 | Decoded received bit |
| out_rdy | input | 1 | Consumer can take a byte; low means full |
| out_vld | output | 1 | out_byte holds a byte this cycle |
| out_byte | output | 8 | Output byte (data, delimiter or escape prefix) |

## Verification
The checker watches every cycle for the following:
- the one-cycle delimiter response;
- the escape prefix always being followed by a framing-code byte;
- silence after a strobe seen while the output is full, or while the receiver is disarmed;
- disarming on the abort pattern;
- output beats occurring only right after strobes.

Stuffed-zero removal, bit order within a byte, loss of a whole byte under back-pressure, and the exact byte sequence of a frame can only be shown by the bench's scenarios. These include a sweep of every byte value through stuffed frames, compared against a stream the bench encodes on its own.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and the emit request type for the frame deframer.
package hdlc_rx_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam logic [7:0]  FLAG_CODE = 8'h7E;
    localparam logic [7:0]  ABRT_MASK = 8'h7F;
    localparam logic [7:0]  ESC_CODE  = 8'h1B;

    // One emit request: first beat always, second beat when two is set.
    typedef struct packed {
        logic             vld;
        logic             two;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } emit_t;
endpackage

// File: rtl/hdlc_rx_hist.sv
// Bit history shift register. Newest bit lands at bit 0.
// Assumes: shift_en is a single-cycle strobe per bit.
module hdlc_rx_hist #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist_nx
);
    logic [W-1:0] hist_q;

    // Next history as seen once the current bit is included.
    assign hist_nx = {hist_q[W-2:0], bit_in};

    // Register the history on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= hist_nx;
    end
endmodule

// File: rtl/hdlc_rx_asm.sv
// Byte assembler: shifts kept bits in from the top (LSB first on the wire).
// Assumes: clr has priority over shift; caller clears on completion.
module hdlc_rx_asm #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] acc_nx,
    output logic         last
);
    localparam int unsigned IW = $clog2(W);

    logic [W-1:0]  acc_q;
    logic [IW-1:0] idx_q;

    // Byte value once the current bit is placed at the top.
    assign acc_nx = {bit_in, acc_q[W-1:1]};
    // Current bit is the final one of the byte.
    assign last   = (idx_q == IW'(W-1));

    // Accumulator and bit index update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (shift) begin
            acc_q <= acc_nx;
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_rx_emit.sv
// Output sequencer: presents one or two bytes on consecutive cycles.
// Assumes: no new request arrives while a second beat is pending.
module hdlc_rx_emit
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  emit_t             req,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte
);
    logic              pend_q;
    logic [BYTE_W-1:0] pend_byte_q;

    // Drive the first beat, then drain the pending second beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld     <= 1'b0;
            out_byte    <= '0;
            pend_q      <= 1'b0;
            pend_byte_q <= '0;
        end else if (req.vld) begin
            out_vld     <= 1'b1;
            out_byte    <= req.b0;
            pend_q      <= req.two;
            pend_byte_q <= req.b1;
        end else if (pend_q) begin
            out_vld     <= 1'b1;
            out_byte    <= pend_byte_q;
            pend_q      <= 1'b0;
        end else begin
            out_vld     <= 1'b0;
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
// Frame deframer top: delimiter and abort detection, stuffed-zero removal,
// LSB-first byte assembly and escape marking of framing-code data bytes.
// Assumes: bit strobes at least two cycles apart; out_rdy low means full.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter logic [7:0]  FLAG      = FLAG_CODE,
    parameter logic [7:0]  ABRT      = ABRT_MASK,
    parameter logic [7:0]  ESC       = ESC_CODE,
    parameter int unsigned STUFF_RUN = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       out_rdy,
    output logic       out_vld,
    output logic [7:0] out_byte
);
    localparam int unsigned W = BYTE_W;
    localparam logic [W-1:0] STUFF_MASK = W'((1 << (STUFF_RUN + 1)) - 1);
    localparam logic [W-1:0] STUFF_PAT  = W'((1 << (STUFF_RUN + 1)) - 2);

    logic [W-1:0] hist_nx;
    logic [W-1:0] acc_nx;
    logic         asm_last;
    logic         asm_clr;
    logic         asm_shift;
    logic         armed;
    logic         armed_d;
    logic         is_flag;
    logic         is_abort;
    logic         is_stuff;
    logic         is_special;
    emit_t        req;

    hdlc_rx_hist #(.W(W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .bit_in   (bit_in),
        .hist_nx  (hist_nx)
    );

    hdlc_rx_asm #(.W(W)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (asm_clr),
        .shift  (asm_shift),
        .bit_in (bit_in),
        .acc_nx (acc_nx),
        .last   (asm_last)
    );

    hdlc_rx_emit u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .out_vld  (out_vld),
        .out_byte (out_byte)
    );

    // Pattern decodes on the history including the current bit.
    assign is_flag    = (hist_nx == FLAG);
    assign is_abort   = ((hist_nx & ABRT) == ABRT);
    assign is_stuff   = ((hist_nx & STUFF_MASK) == STUFF_PAT);
    assign is_special = (acc_nx == FLAG) || (acc_nx == ABRT) || (acc_nx == ESC);

    // Per-bit decision: arm, disarm, drop, assemble or emit.
    always_comb begin
        armed_d   = armed;
        asm_clr   = 1'b0;
        asm_shift = 1'b0;
        req       = '0;
        if (bit_vld) begin
            if (is_flag) begin
                armed_d = out_rdy;
                if (out_rdy) begin
                    asm_clr = 1'b1;
                    req.vld = 1'b1;
                    req.b0  = FLAG;
                end
            end else if (armed) begin
                if (is_abort) begin
                    armed_d = 1'b0;
                end else if (!is_stuff) begin
                    asm_shift = 1'b1;
                    if (asm_last) begin
                        asm_clr = 1'b1;
                        if (!out_rdy) begin
                            armed_d = 1'b0;
                        end else if (is_special) begin
                            req.vld = 1'b1;
                            req.two = 1'b1;
                            req.b0  = ESC;
                            req.b1  = acc_nx;
                        end else begin
                            req.vld = 1'b1;
                            req.b0  = acc_nx;
                        end
                    end
                end
            end
        end
    end

    // Armed state register.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= armed_d;
    end
endmodule

// File: rtl/hdlc_rx_checker.sv
// Cycle-level checks for the frame deframer, attached by bind.
module hdlc_rx_checker
    import hdlc_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       out_rdy,
    input logic       out_vld,
    input logic [7:0] out_byte,
    input logic [7:0] hist_nx,
    input logic       armed
);
    logic prev_vld;
    logic esc_open;

    // Track the last strobe and an open escape prefix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld <= 1'b0;
            esc_open <= 1'b0;
        end else begin
            prev_vld <= bit_vld;
            esc_open <= out_vld && (out_byte == ESC_CODE) && !esc_open;
        end
    end

    a_r10_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld);

    a_r10_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (prev_vld || esc_open));

    a_r7_escape_pair: assert property (@(posedge clk) disable iff (!rst_n)
        esc_open |-> (out_vld && (out_byte == FLAG_CODE || out_byte == ABRT_MASK
                                  || out_byte == ESC_CODE)));

    a_r2_flag_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && out_rdy && hist_nx == FLAG_CODE) |=> (out_vld && out_byte == FLAG_CODE));

    // R8 and R9: a strobe seen while full produces no output beat.
    a_r9_full_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !out_rdy) |=> !out_vld);

    a_r4_abort_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && armed && (hist_nx & ABRT_MASK) == ABRT_MASK) |=> !armed);

    a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !armed && hist_nx != FLAG_CODE) |=> !out_vld);
endmodule

bind hdlc_rx_deframer hdlc_rx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .out_rdy  (out_rdy),
    .out_vld  (out_vld),
    .out_byte (out_byte),
    .hist_nx  (hist_nx),
    .armed    (armed)
);

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       out_rdy = 1'b1;
    logic       out_vld;
    logic [7:0] out_byte;

    int checks = 0;
    int fails  = 0;
    int ones   = 0;
    bit done   = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];

    hdlc_rx_deframer dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .out_rdy(out_rdy), .out_vld(out_vld), .out_byte(out_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Collect every output beat away from the active edge.
    always @(negedge clk) if (rst_n && out_vld) got_q.push_back(out_byte);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        ones = 0;
    endtask

    // Send one byte LSB first with a zero inserted after five ones.
    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                ones++;
                if (ones == 5) begin
                    send_bit(1'b0);
                    ones = 0;
                end
            end else begin
                ones = 0;
            end
        end
    endtask

    task automatic expect_data(input logic [7:0] v);
        if (v == 8'h7E || v == 8'h7F || v == 8'h1B) exp_q.push_back(8'h1B);
        exp_q.push_back(v);
    endtask

    task automatic compare(input string tag);
        repeat (4) @(negedge clk);
        check({tag, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(tag, got_q[i], exp_q[i]);
        exp_q.delete();
        got_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_vld at reset", out_vld, 1'b0);
        rst_n = 1'b1;

        // R3: bits before any delimiter are ignored.
        send_byte(8'h55); send_byte(8'h00); send_byte(8'hA5);
        compare("R3");

        // R2: delimiter byte visible the cycle after its last strobe.
        send_flag();
        check("R2 vld timing", out_vld, 1'b1);
        check("R2 flag byte", out_byte, 8'h7E);
        exp_q.push_back(8'h7E);
        // R7: escape then data on consecutive cycles.
        send_byte(8'h7E);
        check("R7 escape beat", {out_vld, out_byte}, {1'b1, 8'h1B});
        @(negedge clk);
        check("R7 data beat", {out_vld, out_byte}, {1'b1, 8'h7E});
        expect_data(8'h7E);
        send_byte(8'h7F); expect_data(8'h7F);
        send_byte(8'h1B); expect_data(8'h1B);
        send_flag(); exp_q.push_back(8'h7E);
        compare("R7");

        // R5: runs of ones force stuffed zeros that must be dropped.
        send_flag(); exp_q.push_back(8'h7E);
        send_byte(8'hFF); expect_data(8'hFF);
        send_byte(8'h3E); expect_data(8'h3E);
        send_byte(8'hF8); expect_data(8'hF8);
        send_byte(8'h1F); expect_data(8'h1F);
        send_flag(); exp_q.push_back(8'h7E);
        compare("R5");

        // R6: sweep of all byte values in frames of sixteen.
        for (int f = 0; f < 16; f++) begin
            send_flag(); exp_q.push_back(8'h7E);
            for (int j = 0; j < 16; j++) begin
                send_byte(8'(f * 16 + j));
                expect_data(8'(f * 16 + j));
            end
        end
        send_flag(); exp_q.push_back(8'h7E);
        compare("R6");

        // R4: abort mid-byte; following bits ignored until next delimiter.
        send_flag(); exp_q.push_back(8'h7E);
        send_byte(8'h42); expect_data(8'h42);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        ones = 0;
        send_byte(8'h55); send_byte(8'h24);
        send_flag(); exp_q.push_back(8'h7E);
        send_byte(8'h99); expect_data(8'h99);
        send_flag(); exp_q.push_back(8'h7E);
        compare("R4");

        // R8: delimiter while full is not emitted and does not arm.
        out_rdy = 1'b0;
        send_flag();
        out_rdy = 1'b1;
        send_byte(8'h11); send_byte(8'h22);
        compare("R8");

        // R9: byte completed while full is dropped and disarms.
        send_flag(); exp_q.push_back(8'h7E);
        send_byte(8'h33); expect_data(8'h33);
        out_rdy = 1'b0;
        send_byte(8'h7E);
        out_rdy = 1'b1;
        send_byte(8'h44); send_byte(8'h66);
        send_flag(); exp_q.push_back(8'h7E);
        send_byte(8'h01); expect_data(8'h01);
        compare("R9");

        // R10: no beat outside strobe response.
        repeat (5) @(negedge clk);
        check("R10 idle out_vld", out_vld, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule